// File: doc/BRIEF.md
# PWM Channel Polarity and Fault Output Stage

This block is the last stage between eight internal pulse-width channels and the device pins. Each internal channel signal is active high. A per-channel polarity bit decides whether the pin shows that signal as-is or inverted. The polarity bits live in one 32-bit register on a simple write-enable/address/data bus. Writes to that register land only while a separate protect-disable flag is asserted.

When fault control is enabled and the fault input is high, every pin is forced to the inactive level of its channel. That inactive level is exactly the channel's polarity bit. Pins are registered, so a change on the channel inputs, the fault inputs or the polarity register shows at the pins one clock later.

The asynchronous active-low reset is released synchronously inside the block.

Top module: `pwm_pol_fault_stage`

## Requirements
- R1: While reset is active, and after it is released, all polarity bits are 0 and every pin reads 0.
- R2: The polarity register sits at byte address 0x10. Bit n holds the polarity of channel n, for n = 0 to 7. Bits 31 to 8 always read 0, and writing them has no effect. A read of any other address returns 0, and writes to other addresses change nothing.
- R3: A write to the polarity register updates the bits only when the protect-disable input is 1 during the write cycle. Otherwise the register keeps its value.
- R4: With no active fault, each pin equals its channel input XOR its polarity bit. The pin updates one clock after the input is sampled.
- R5: When the fault-enable input and the fault input are both 1 at a clock edge, every pin takes its channel's polarity bit at that edge. This applies whatever the channel inputs are.
- R6: While fault-enable is 0, the fault input has no effect on the pins.
- R7: A read of the polarity register returns the current bits whatever the value of the protect-disable input.
- R8: One clock after the fault or the fault-enable drops, the pins follow the XOR rule again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| prot_off | input | 1 | Protect-disable flag; 1 allows polarity writes |
| chan_raw | input | 8 | Active-high internal channel signals |
| flt_en | input | 1 | Fault control enable |
| flt_in | input | 1 | Fault detected |
| pin_out | output | 8 | Pin levels |

## Verification
The assertions check four properties on every cycle:
- the protected register holds still under a blocked write;
- the reserved read bits stay zero;
- the pins obey either the XOR rule or the safe-level rule, taken from the previous cycle's inputs and polarity;
- a fault with fault control disabled leaves the XOR path alone.

Only the bench scenarios can show three other behaviours:
- the register decode, across both the right and wrong addresses;
- the complete sweep over all 256 polarity patterns;
- recovery from a fault that is released mid-stream.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
  localparam int unsigned CH_COUNT  = 8;
  localparam int unsigned BUS_DW    = 32;
  localparam int unsigned BUS_AW    = 8;
  localparam logic [7:0]  POL_OFFS  = 8'h10;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_pol_regs.sv
module pwm_pol_regs #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 8,
  parameter logic [AW-1:0] POL_ADDR = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          prot_off,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] pol
);
  localparam int unsigned PAD_W = DW - NCH;

  logic           addr_hit;
  logic           wr_en;
  logic [NCH-1:0] pol_q;
  logic [NCH-1:0] pol_d;

  assign addr_hit = (addr == POL_ADDR);
  assign wr_en    = we & addr_hit & prot_off;

  always_comb begin
    pol_d = pol_q;
    if (wr_en) pol_d = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else        pol_q <= pol_d;
  end

  always_comb begin
    rdata = '0;
    if (addr_hit) rdata = {{PAD_W{1'b0}}, pol_q};
  end

  assign pol = pol_q;

  // R3: a write while protected leaves the bits untouched
  assert_wp_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !prot_off) |=> $stable(pol_q));

  // R2: reserved read bits stay zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NCH] == '0);
endmodule

// File: rtl/pwm_pin_cell.sv
module pwm_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  input  logic force_safe,
  output logic pin
);
  logic pin_q;
  logic pin_d;

  always_comb begin
    if (force_safe) pin_d = pol;
    else            pin_d = raw ^ pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/pwm_pol_fault_stage.sv
module pwm_pol_fault_stage
  import pwm_stage_pkg::*;
#(
  parameter int unsigned NCH = CH_COUNT,
  parameter int unsigned DW  = BUS_DW,
  parameter int unsigned AW  = BUS_AW,
  parameter logic [AW-1:0] POL_ADDR = POL_OFFS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           prot_off,
  input  logic [NCH-1:0] chan_raw,
  input  logic           flt_en,
  input  logic           flt_in,
  output logic [NCH-1:0] pin_out
);
  logic           rst_n_s;
  logic [NCH-1:0] pol;
  logic           fault_act;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pwm_pol_regs #(.NCH(NCH), .DW(DW), .AW(AW), .POL_ADDR(POL_ADDR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .prot_off (prot_off),
    .rdata    (bus_rdata),
    .pol      (pol)
  );

  assign fault_act = flt_en & flt_in;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    pwm_pin_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .raw        (chan_raw[gi]),
      .pol        (pol[gi]),
      .force_safe (fault_act),
      .pin        (pin_out[gi])
    );
  end

  // R5: an active fault drives every pin to its polarity bit
  assert_fault_safe_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flt_en && flt_in) |=> (pin_out == $past(pol)));

  // R4: no fault, so pins follow raw XOR polarity one clock later
  assert_xor_path_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(flt_en && flt_in) |=> (pin_out == $past(chan_raw ^ pol)));

  // R6: a fault with fault control off has no effect
  assert_fault_gate_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flt_in && !flt_en) |=> (pin_out == $past(chan_raw ^ pol)));
endmodule

// File: tb/pwm_pol_fault_stage_tb.sv
module pwm_pol_fault_stage_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        prot_off;
  logic [7:0]  chan_raw;
  logic        flt_en;
  logic        flt_in;
  logic [7:0]  pin_out;

  int   n_chk;
  int   n_fail;
  logic [7:0] pol_m;
  bit   done;

  localparam logic [7:0] PADDR = 8'h10;

  pwm_pol_fault_stage u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_off(prot_off),
    .chan_raw(chan_raw), .flt_en(flt_en), .flt_in(flt_in), .pin_out(pin_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_pins(input logic [7:0] raw, input logic [7:0] pol,
                                          input logic fen, input logic fin);
    return (fen && fin) ? pol : (raw ^ pol);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; prot_off = p;
    @(negedge clk);
    bus_we = 1'b0; prot_off = 1'b0;
    if (p && a == PADDR) pol_m = d[7:0];
  endtask

  task automatic bus_read(input string req, input logic [7:0] a, input logic p);
    @(negedge clk);
    bus_addr = a; prot_off = p;
    #1;
    chk(req, bus_rdata, (a == PADDR) ? {24'h0, pol_m} : 32'h0);
    prot_off = 1'b0;
  endtask

  task automatic pin_step(input string req, input logic [7:0] raw, input logic fen, input logic fin);
    @(negedge clk);
    chan_raw = raw; flt_en = fen; flt_in = fin;
    @(negedge clk);
    chk(req, {24'h0, pin_out}, {24'h0, exp_pins(raw, pol_m, fen, fin)});
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    n_chk = 0; n_fail = 0; pol_m = 8'h00; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = PADDR; bus_wdata = '0;
    prot_off = 1'b0; chan_raw = 8'hFF; flt_en = 1'b0; flt_in = 1'b0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pins in reset", {24'h0, pin_out}, 32'h0);
    chk("R1 pol in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chan_raw = 8'h00;
    @(negedge clk);
    chk("R1 pins after reset", {24'h0, pin_out}, 32'h0);

    // R3: protected write dropped
    bus_write(PADDR, 32'h0000_00A5, 1'b0);
    bus_read("R3 blocked write", PADDR, 1'b0);
    // R2: reserved bits and address decode
    bus_write(PADDR, 32'hFFFF_FF3C, 1'b1);
    bus_read("R2 reserved bits read zero", PADDR, 1'b0);
    bus_write(8'h14, 32'h0000_00FF, 1'b1);
    bus_read("R2 other address write ignored", PADDR, 1'b0);
    bus_read("R2 other address reads zero", 8'h14, 1'b1);
    // R7: read independent of protect flag
    bus_read("R7 read with prot_off=1", PADDR, 1'b1);
    bus_read("R7 read with prot_off=0", PADDR, 1'b0);

    // R4: all 256 polarity patterns
    for (int p = 0; p < 256; p++) begin
      bus_write(PADDR, 32'(p), 1'b1);
      r = 8'($urandom);
      pin_step("R4 xor rule", r, 1'b0, 1'b0);
      pin_step("R4 xor rule inverted", ~r, 1'b1, 1'b0);
    end

    // R5, R6, R8: fault behaviour
    for (int k = 0; k < 40; k++) begin
      bus_write(PADDR, $urandom, 1'b1);
      r = 8'($urandom);
      pin_step("R5 fault forces safe level", r, 1'b1, 1'b1);
      pin_step("R5 fault safe level, new raw", ~r, 1'b1, 1'b1);
      pin_step("R6 fault ignored when disabled", r, 1'b0, 1'b1);
      pin_step("R8 recovery after fault", ~r, 1'b1, 1'b0);
    end
    // R5 corner: pins with all-ones pattern and raw all-ones
    bus_write(PADDR, 32'hFF, 1'b1);
    pin_step("R5 safe level all ones", 8'hFF, 1'b1, 1'b1);
    bus_write(PADDR, 32'h00, 1'b1);
    pin_step("R5 safe level all zeros", 8'hFF, 1'b1, 1'b1);
    // R3: blocked write during fault does not change safe level
    bus_write(PADDR, 32'hFF, 1'b0);
    pin_step("R3 safe level unchanged by blocked write", 8'h00, 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule